// File: doc/BRIEF.md
# Lockable Flash Controller Register Bank

This block is the software-visible register file of a serial flash controller. A host reaches it with aligned 32-bit reads and writes over a simple bus made of one write strobe, a byte address and a data word. Reads are combinational on the address. The bank holds three configuration words:

- one for memory-mapped reads,
- one for memory-mapped writes,
- one for software-driven (user-mode) transactions.

It also holds a control/status word, a command byte register, an address register, four outgoing data words, four incoming data words and a global configuration word.

The live values are driven out to the transaction engines that sit next to the bank. Those engines report back in two ways: a completion strobe, and a load port that fills the incoming data words.

Each of the three configuration words locks itself through its top bit. The user-mode configuration word also has a second, narrower lock that freezes only a few of its fields. The control/status word mixes two behaviours. Its ready flag is cleared by writing 1 to it. Its execute flag is sticky: software can set it, and only the engine can clear it. Every write of the execute flag as 1 produces a one-cycle start pulse toward the user-mode engine.

Top module: `fcr_regbank`

## Requirements
- R1: After reset the words read: user-mode config 0x00000400, control/status 0x00010000, command 0x0000000B, global config 0x0000000B. Every other offset reads 0.
- R2: Once bit 31 of the read-config, write-config or user-mode-config word is set, that word ignores further writes. Each such dropped write raises `wr_err` for one cycle, in the cycle after the write.
- R3: While bit 30 of the user-mode config is set, the bits in mask 0x00000403 keep their old values on a write, and all other bits take the written value.
- R4: Writing 1 to control/status bit 24 (ready) clears it, and writing 0 leaves it unchanged. A pulse on `eng_done` sets it.
- R5: Control/status bit 0 (execute) is ORed with the written value. A pulse on `eng_done` clears it in the next cycle, unless the same write sets it again.
- R6: `exec_start` is high for exactly the one cycle that follows each control/status write with bit 0 equal to 1.
- R7: The four incoming data words can be written only through the engine load port. A bus write to them changes nothing and raises `wr_err`.
- R8: A write to an unused offset changes nothing and raises `wr_err`, and a read from it returns 0. Writes to the protection window (word 6, byte offsets 0x40 to 0x64) raise no error, have no effect, and those words read 0.
- R9: The word layout at byte offsets is as follows: 0x00 read-config, 0x04 write-config, 0x08 user-mode config, 0x0C control/status, 0x10 command, 0x14 address, 0x20 to 0x2C outgoing data 0 to 3, 0x30 to 0x3C incoming data 0 to 3, 0x78 global config. Each of these is driven on its matching output.
- R10: `rdy_irq` is high when control/status bit 24 and bit 25 (ready enable) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Read data for `addr` |
| wr_err | output | 1 | The previous write was dropped or illegal |
| eng_done | input | 1 | User-mode transaction finished |
| eng_load | input | 1 | Engine writes an incoming data word |
| eng_load_idx | input | 2 | Incoming data word index |
| eng_load_data | input | 32 | Incoming data value |
| rdcfg_o | output | 32 | Read-config word |
| wrcfg_o | output | 32 | Write-config word |
| umcfg_o | output | 32 | User-mode config word |
| cts_o | output | 32 | Control/status word |
| cmd_o | output | 32 | Command word |
| faddr_o | output | 32 | Flash address word |
| wdat_o | output | 128 | Outgoing data words, word 0 in the low bits |
| gcfg_o | output | 32 | Global config word |
| exec_start | output | 1 | Start pulse to the user-mode engine |
| rdy_irq | output | 1 | Ready interrupt |

## Verification
Directed sequences cover the lock corners:

- setting a top-bit lock and then trying to overwrite the word;
- setting the narrow lock with the masked bits opposite to the new data, which separates a full freeze from a masked one;
- on the control/status word, writing 0 and 1 to the ready and execute flags with and without an engine completion, which separates write-1-to-clear, sticky and plain storage.

A seeded random phase then mixes writes to every one of the 32 word offsets, including unused and read-only ones, with engine completions and loads. After each step it compares `wr_err`, `exec_start`, `rdy_irq` and a readback against a bench model. That catches decode slips between neighbouring offsets.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
    localparam int DW          = 32;
    localparam int DATA_WORDS  = 4;
    localparam int LOCK_BIT    = 31;
    localparam int MODE_BIT    = 30;
    localparam int RDY_BIT     = 24;
    localparam int RDYIE_BIT   = 25;
    localparam int EXEC_BIT    = 0;
    localparam logic [DW-1:0] MODE_MASK = 32'h0000_0403;
    localparam logic [DW-1:0] UMCFG_RST = 32'h0000_0400;
    localparam logic [DW-1:0] CTS_RST   = 32'h0001_0000;
    localparam logic [DW-1:0] CMD_RST   = 32'h0000_000B;
    localparam logic [DW-1:0] GCFG_RST  = 32'h0000_000B;
    localparam logic [4:0] W_CTS  = 5'd3;
    localparam logic [4:0] W_CMD  = 5'd4;
    localparam logic [4:0] W_ADDR = 5'd5;
    localparam logic [4:0] W_WD0  = 5'd8;
    localparam logic [4:0] W_RD0  = 5'd12;
    localparam logic [4:0] W_GCFG = 5'd30;

    typedef enum logic [2:0] {
        K_UNUSED, K_CFG, K_CTS, K_PLAIN, K_WDATA, K_RDATA, K_PROT
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [4:0] word;
    } dec_t;

    function automatic kind_e word_kind(logic [4:0] w);
        if (w <= 5'd2)                     return K_CFG;
        if (w == W_CTS)                    return K_CTS;
        if (w == W_CMD || w == W_ADDR)     return K_PLAIN;
        if (w == W_GCFG)                   return K_PLAIN;
        if (w == 5'd6)                     return K_PROT;
        if (w >= W_WD0 && w < W_RD0)       return K_WDATA;
        if (w >= W_RD0 && w < 5'd16)       return K_RDATA;
        if (w >= 5'd16 && w <= 5'd25)      return K_PROT;
        return K_UNUSED;
    endfunction

    function automatic logic [DW-1:0] mode_merge(logic [DW-1:0] old_v, logic [DW-1:0] new_v);
        if (old_v[MODE_BIT]) return (new_v & ~MODE_MASK) | (old_v & MODE_MASK);
        return new_v;
    endfunction

    function automatic logic [DW-1:0] cts_merge(logic [DW-1:0] old_v, logic [DW-1:0] new_v);
        logic [DW-1:0] r;
        r = new_v;
        r[RDY_BIT]  = new_v[RDY_BIT] ? 1'b0 : old_v[RDY_BIT];
        r[EXEC_BIT] = new_v[EXEC_BIT] | old_v[EXEC_BIT];
        return r;
    endfunction
endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int WORD_MSB = 6;
    logic in_range;

    generate
        if (ADDR_W > WORD_MSB + 1) begin : g_hi
            assign in_range = (addr[ADDR_W-1:WORD_MSB+1] == '0);
        end else begin : g_nohi
            assign in_range = 1'b1;
        end
    endgenerate

    always_comb begin
        dec.word = addr[WORD_MSB:2];
        dec.kind = in_range ? word_kind(addr[WORD_MSB:2]) : K_UNUSED;
    end
endmodule

// File: rtl/fcr_cfg_reg.sv
module fcr_cfg_reg
    import fcr_pkg::*;
#(
    parameter logic [31:0] RESET     = '0,
    parameter bit          MODE_LOCK = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q,
    output logic          drop
);
    logic [DW-1:0] next_v;

    generate
        if (MODE_LOCK) begin : g_mode
            assign next_v = mode_merge(q, wdata);
        end else begin : g_plain
            assign next_v = wdata;
        end
    endgenerate

    assign drop = we && q[LOCK_BIT];

    always_ff @(posedge clk) begin
        if (rst)                       q <= RESET;
        else if (we && !q[LOCK_BIT])   q <= next_v;
    end
endmodule

// File: rtl/fcr_status.sv
module fcr_status
    import fcr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          done,
    output logic [DW-1:0] cts,
    output logic          start
);
    logic [DW-1:0] nxt;

    always_comb begin
        nxt = we ? cts_merge(cts, wdata) : cts;
        if (done) begin
            nxt[RDY_BIT]  = 1'b1;
            nxt[EXEC_BIT] = we && wdata[EXEC_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cts   <= CTS_RST;
            start <= 1'b0;
        end else begin
            cts   <= nxt;
            start <= we && wdata[EXEC_BIT];
        end
    end
endmodule

// File: rtl/fcr_regbank.sv
module fcr_regbank
    import fcr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    output logic                     wr_err,
    input  logic                     eng_done,
    input  logic                     eng_load,
    input  logic [1:0]               eng_load_idx,
    input  logic [31:0]              eng_load_data,
    output logic [31:0]              rdcfg_o,
    output logic [31:0]              wrcfg_o,
    output logic [31:0]              umcfg_o,
    output logic [31:0]              cts_o,
    output logic [31:0]              cmd_o,
    output logic [31:0]              faddr_o,
    output logic [127:0]             wdat_o,
    output logic [31:0]              gcfg_o,
    output logic                     exec_start,
    output logic                     rdy_irq
);
    localparam int NCFG  = 3;
    localparam int IDX_W = $clog2(DATA_WORDS);

    dec_t          dec;
    logic [DW-1:0] cfg_q [NCFG];
    logic [NCFG-1:0] cfg_drop;
    logic [DW-1:0] cts_q, cmd_q, faddr_q, gcfg_q;
    logic [DW-1:0] wd_q [DATA_WORDS];
    logic [DW-1:0] rd_q [DATA_WORDS];
    logic          bad_wr;

    fcr_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .dec(dec));

    generate
        for (genvar g = 0; g < NCFG; g++) begin : g_cfg
            fcr_cfg_reg #(
                .RESET     ((g == 2) ? UMCFG_RST : 32'h0),
                .MODE_LOCK (g == 2)
            ) u_cfg (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_en && dec.kind == K_CFG && dec.word == 5'(g)),
                .wdata (wdata),
                .q     (cfg_q[g]),
                .drop  (cfg_drop[g])
            );
        end
    endgenerate

    fcr_status u_status (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en && dec.kind == K_CTS),
        .wdata (wdata),
        .done  (eng_done),
        .cts   (cts_q),
        .start (exec_start)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= CMD_RST;
            faddr_q <= '0;
            gcfg_q  <= GCFG_RST;
        end else if (wr_en && dec.kind == K_PLAIN) begin
            if (dec.word == W_CMD)  cmd_q   <= wdata;
            if (dec.word == W_ADDR) faddr_q <= wdata;
            if (dec.word == W_GCFG) gcfg_q  <= wdata;
        end
    end

    generate
        for (genvar d = 0; d < DATA_WORDS; d++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst) begin
                    wd_q[d] <= '0;
                    rd_q[d] <= '0;
                end else begin
                    if (wr_en && dec.kind == K_WDATA && dec.word[IDX_W-1:0] == IDX_W'(d))
                        wd_q[d] <= wdata;
                    if (eng_load && eng_load_idx == IDX_W'(d))
                        rd_q[d] <= eng_load_data;
                end
            end
            assign wdat_o[d*DW +: DW] = wd_q[d];
        end
    endgenerate

    assign bad_wr = wr_en && ((|cfg_drop) || dec.kind == K_RDATA || dec.kind == K_UNUSED);

    always_ff @(posedge clk) begin
        if (rst) wr_err <= 1'b0;
        else     wr_err <= bad_wr;
    end

    always_comb begin
        unique case (dec.kind)
            K_CFG:   rdata = (dec.word < 5'(NCFG)) ? cfg_q[dec.word[1:0]] : '0;
            K_CTS:   rdata = cts_q;
            K_PLAIN: rdata = (dec.word == W_CMD)  ? cmd_q :
                             (dec.word == W_ADDR) ? faddr_q : gcfg_q;
            K_WDATA: rdata = wd_q[dec.word[IDX_W-1:0]];
            K_RDATA: rdata = rd_q[dec.word[IDX_W-1:0]];
            default: rdata = '0;
        endcase
    end

    assign rdcfg_o = cfg_q[0];
    assign wrcfg_o = cfg_q[1];
    assign umcfg_o = cfg_q[2];
    assign cts_o   = cts_q;
    assign cmd_o   = cmd_q;
    assign faddr_o = faddr_q;
    assign gcfg_o  = gcfg_q;
    assign rdy_irq = cts_q[RDY_BIT] && cts_q[RDYIE_BIT];
endmodule

// File: rtl/fcr_regbank_chk.sv
module fcr_regbank_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              wr_err,
    input logic              eng_done,
    input logic [31:0]       rdcfg_o,
    input logic [31:0]       wrcfg_o,
    input logic [31:0]       umcfg_o,
    input logic [31:0]       cts_o,
    input logic              exec_start
);
    logic cts_hit;
    assign cts_hit = wr_en && (addr[ADDR_W-1:2] == (ADDR_W-2)'(3));

    a_r2_rdcfg_frozen: assert property (@(posedge clk) disable iff (rst)
        rdcfg_o[31] |=> $stable(rdcfg_o));
    a_r2_wrcfg_frozen: assert property (@(posedge clk) disable iff (rst)
        wrcfg_o[31] |=> $stable(wrcfg_o));
    a_r3_mode_mask: assert property (@(posedge clk) disable iff (rst)
        umcfg_o[30] |=> ((umcfg_o & 32'h403) == ($past(umcfg_o) & 32'h403)));
    a_r4_ready_held: assert property (@(posedge clk) disable iff (rst)
        (cts_o[24] && !(cts_hit && wdata[24])) |=> cts_o[24]);
    a_r5_exec_sticky: assert property (@(posedge clk) disable iff (rst)
        (cts_o[0] && !eng_done) |=> cts_o[0]);
    a_r6_start_cause: assert property (@(posedge clk) disable iff (rst)
        exec_start |-> $past(cts_hit && wdata[0]));
    a_r8_err_cause: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> $past(wr_en));
endmodule

bind fcr_regbank fcr_regbank_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .wr_err(wr_err), .eng_done(eng_done), .rdcfg_o(rdcfg_o),
    .wrcfg_o(wrcfg_o), .umcfg_o(umcfg_o), .cts_o(cts_o),
    .exec_start(exec_start)
);

// File: tb/fcr_regbank_tb_top.sv
module fcr_regbank_tb_top;
    localparam int ADDR_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic wr_err, exec_start, rdy_irq;
    logic eng_done = 1'b0, eng_load = 1'b0;
    logic [1:0] eng_load_idx = '0;
    logic [31:0] eng_load_data = '0;
    logic [31:0] rdcfg_o, wrcfg_o, umcfg_o, cts_o, cmd_o, faddr_o, gcfg_o;
    logic [127:0] wdat_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] mdl [32];

    always #2.5 clk = ~clk;

    fcr_regbank #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wr_err(wr_err), .eng_done(eng_done),
        .eng_load(eng_load), .eng_load_idx(eng_load_idx),
        .eng_load_data(eng_load_data), .rdcfg_o(rdcfg_o), .wrcfg_o(wrcfg_o),
        .umcfg_o(umcfg_o), .cts_o(cts_o), .cmd_o(cmd_o), .faddr_o(faddr_o),
        .wdat_o(wdat_o), .gcfg_o(gcfg_o), .exec_start(exec_start),
        .rdy_irq(rdy_irq)
    );

    function automatic logic [31:0] rst_val(int w);
        case (w)
            2: return 32'h0000_0400;
            3: return 32'h0001_0000;
            4, 30: return 32'h0000_000B;
            default: return 32'h0;
        endcase
    endfunction

    // Model of one bus write: updates mdl, returns expected error and start.
    task automatic mdl_wr(input int w, input logic [31:0] d, output bit err, output bit st);
        err = 1'b0;
        st  = (w == 3) && d[0];
        if (w <= 2) begin
            if (mdl[w][31]) err = 1'b1;
            else if (w == 2 && mdl[2][30]) mdl[2] = (d & ~32'h403) | (mdl[2] & 32'h403);
            else mdl[w] = d;
        end else if (w == 3) begin
            logic [31:0] n;
            n = d;
            n[24] = d[24] ? 1'b0 : mdl[3][24];
            n[0]  = d[0] | mdl[3][0];
            mdl[3] = n;
        end else if (w == 4 || w == 5 || w == 30 || (w >= 8 && w <= 11)) begin
            mdl[w] = d;
        end else if (w >= 12 && w <= 15) begin
            err = 1'b1;
        end else if (w == 6 || (w >= 16 && w <= 25)) begin
            err = 1'b0;
        end else begin
            err = 1'b1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input int w, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(w * 4); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int w, output logic [31:0] d);
        addr = ADDR_W'(w * 4);
        #1;
        d = rdata;
    endtask

    task automatic do_wr(input string req, input int w, input logic [31:0] d);
        bit e, s;
        logic [31:0] r;
        mdl_wr(w, d, e, s);
        bus_wr(w, d);
        check({req, " wr_err"}, {31'b0, wr_err}, {31'b0, e});
        check({req, " exec_start"}, {31'b0, exec_start}, {31'b0, s});
        bus_rd(w, r);
        check({req, " readback"}, r, mdl[w]);
    endtask

    task automatic eng_finish();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
        mdl[3][24] = 1'b1;
        mdl[3][0]  = 1'b0;
    endtask

    task automatic eng_fill(input logic [1:0] i, input logic [31:0] d);
        @(negedge clk); eng_load = 1'b1; eng_load_idx = i; eng_load_data = d;
        @(negedge clk); eng_load = 1'b0;
        mdl[12 + i] = d;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) mdl[i] = rst_val(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every offset holds its reset value
        for (int w = 0; w < 32; w++) begin
            bus_rd(w, r);
            check("R1 reset value", r, rst_val(w));
        end
        check("R1 exec_start idle", {31'b0, exec_start}, 32'h0);

        // R2: top-bit lock on read-config and write-config
        do_wr("R2 lock set", 0, 32'h8000_1234);
        do_wr("R2 locked write dropped", 0, 32'h0000_5678);
        check("R2 rdcfg_o frozen", rdcfg_o, 32'h8000_1234);
        do_wr("R2 wrcfg plain", 1, 32'h0000_00AA);

        // R3: narrow lock keeps mask 0x403, other bits update
        do_wr("R3 mode lock set", 2, 32'h4000_0400);
        do_wr("R3 masked write", 2, 32'h0012_0003);
        check("R3 umcfg_o merged", umcfg_o, 32'h0012_0400);
        do_wr("R3 unlocked write", 2, 32'h0000_0003);

        // R5/R6: execute is sticky and starts the engine
        do_wr("R6 exec write 1", 3, 32'h0000_0001);
        do_wr("R5 exec write 0 keeps", 3, 32'h0000_0000);
        eng_finish();
        bus_rd(3, r);
        check("R5 engine clears exec / R4 sets ready", r, mdl[3]);
        check("R4 ready set by engine", {31'b0, cts_o[24]}, 32'h1);

        // R4/R10: ready W0 keeps, W1 clears; interrupt follows enable
        do_wr("R4 ready write 0 keeps", 3, 32'h0200_0000);
        check("R10 irq raised", {31'b0, rdy_irq}, 32'h1);
        do_wr("R4 ready write 1 clears", 3, 32'h0300_0000);
        check("R10 irq dropped", {31'b0, rdy_irq}, 32'h0);

        // R7: incoming data only from the engine
        eng_fill(2'd2, 32'hCAFE_0002);
        bus_rd(14, r);
        check("R7 engine load visible", r, 32'hCAFE_0002);
        do_wr("R7 bus write ignored", 14, 32'h1111_1111);

        // R8: unused offsets and protection window
        do_wr("R8 unused offset", 31, 32'hFFFF_FFFF);
        do_wr("R8 unused gap", 7, 32'h1234_5678);
        do_wr("R8 protection cmd", 16, 32'hABCD_EF01);
        do_wr("R8 protection cfg", 6, 32'h0000_0400);

        // R9: layout and exported values
        do_wr("R9 global config", 30, 32'h0000_5A5A);
        check("R9 gcfg_o", gcfg_o, 32'h0000_5A5A);
        do_wr("R9 write data 1", 9, 32'h7777_0001);
        check("R9 wdat_o word1", wdat_o[63:32], 32'h7777_0001);
        do_wr("R9 command", 4, 32'h0000_009F);
        check("R9 cmd_o", cmd_o, 32'h0000_009F);
        do_wr("R9 flash address", 5, 32'h0012_3456);
        check("R9 faddr_o", faddr_o, 32'h0012_3456);

        // Random mix over all offsets (R2 R3 R4 R5 R7 R8 R9 R10)
        for (int it = 0; it < 600; it++) begin
            int w;
            logic [31:0] d;
            int pick;
            pick = int'($urandom % 12);
            if (pick == 0) begin
                eng_finish();
                check("R10 irq after done", {31'b0, rdy_irq}, {31'b0, mdl[3][24] & mdl[3][25]});
            end else if (pick == 1) begin
                eng_fill(2'($urandom % 4), $urandom);
            end else begin
                w = int'($urandom % 32);
                d = $urandom;
                if (w <= 2 && ($urandom % 8) != 0) d[31] = 1'b0;
                if (w == 2 && ($urandom % 3) != 0) d[30] = 1'b0;
                do_wr("R8 random write", w, d);
            end
            w = int'($urandom % 32);
            bus_rd(w, r);
            check("R9 random readback", r, mdl[w]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule